// File: doc/BRIEF.md
# Time-Division Bus Arbiter

This block shares one system bus among a set of processors by dividing bus time into equal windows and handing the windows out in a fixed circular order. A slot timer counts bus cycles; when the current window runs out, ownership moves to the next processor index, whether or not anyone is requesting. As a result, the share each processor receives does not depend on where it sits on the bus or on what the other processors are doing.

The window length is programmable in bus cycles. It is sampled while reset is held, and again on the last cycle of every window, so a new value takes effect only at the next handover. The owner of the current window receives a one-hot grant while it keeps its request line high. If it lets the request line fall, it gives up the rest of that window.

An optional skip-idle mode cuts short any window whose owner is not requesting. In that mode, bus time passes quickly to the next processor. The arbiter reports three things: the owner index, a one-hot grant, and a one-cycle strobe on the first cycle of each new window.

Top module: `tslice_arbiter`

## Requirements
- R1: With skip-idle off, every window lasts exactly the programmed number of cycles. Over K complete rotations, a processor that requests all the time is granted for exactly K times the window length in cycles.
- R2: Ownership visits indices 0, 1, ..., N-1 and then returns to 0. The owner changes only at the end of a window.
- R3: While reset is held and on the first cycle after it, the owner index is 0, the strobe is low, and no grant is given unless processor 0 requests.
- R4: `boundary_o` is high for exactly one cycle, the first cycle of each new window. It is never high on the first window after reset.
- R5: `grant_o` is one-hot or zero. Bit i is high only when i is the current owner and `req_i[i]` is high. The requests of other processors have no effect on the grant.
- R6: Once the owner's request is seen low in any cycle of its window, no grant is given for the remainder of that window, even if the request returns.
- R7: With `skip_idle_i` = 1, any cycle in which the owner is not requesting is the last cycle of its window. Ownership moves to the next index on the following cycle.
- R8: A change on `slice_len_i` does not alter the running window. The value present on the last cycle of a window sets the length of the next window.
- R9: A programmed length of 0 behaves as a length of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_REQ | Per-processor bus request |
| slice_len_i | input | LEN_W | Window length in bus cycles (0 treated as 1) |
| skip_idle_i | input | 1 | End a window early when its owner is idle |
| grant_o | output | N_REQ | One-hot bus grant |
| owner_o | output | IDX_W | Index of the current window owner |
| boundary_o | output | 1 | One-cycle strobe on the first cycle of each window |

## Verification
The bench tracks the owner, the grant and the strobe cycle by cycle against a schedule computed from the window length. A counter that wraps one cycle early or late would show up as skewed per-processor grant totals and as misplaced strobes. Further directed cases cover three failure modes:
- An owner that drops and then raises its request inside its window: a design without the forfeit rule would grant again.
- Skip-idle mode with only one active requester: a design that ignores the mode would keep idle owners for the full window.
- A window length changed mid-window, and a length of zero: an arbiter that applies the new length at once would shorten the running window, and one without the zero clamp would hang in a window that never ends.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    localparam int TSA_DEF_REQ   = 4;
    localparam int TSA_DEF_LEN_W = 8;
endpackage

// File: rtl/tsa_slot_timer.sv
module tsa_slot_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] len_i,
    input  logic             end_early_i,
    output logic             slot_end_o
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
    } timer_t;

    timer_t st_d, st_q;
    logic [LEN_W-1:0] len_clamped;

    always_comb begin
        len_clamped = (len_i == '0) ? LEN_W'(1) : len_i;
        slot_end_o  = end_early_i || (st_q.cnt == st_q.len - LEN_W'(1));
        st_d        = st_q;
        if (slot_end_o) begin
            st_d.cnt = '0;
            st_d.len = len_clamped;
        end else begin
            st_d.cnt = st_q.cnt + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.len <= len_clamped;
        end else begin
            st_q <= st_d;
        end
    end

    p_len_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.len != '0);
    p_cnt_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.len);
    p_len_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_end_o |=> $stable(st_q.len));
endmodule

// File: rtl/tsa_rotor.sv
module tsa_rotor #(
    parameter int N_REQ = 4,
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    output logic [IDX_W-1:0] owner_o,
    output logic             boundary_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_REQ - 1);

    typedef struct packed {
        logic [IDX_W-1:0] owner;
        logic             bnd;
    } rotor_t;

    rotor_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.bnd = advance_i;
        if (advance_i)
            st_d.owner = (st_q.owner == LAST_IDX) ? '0 : st_q.owner + IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign owner_o    = st_q.owner;
    assign boundary_o = st_q.bnd;

    p_owner_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(owner_o));
    p_owner_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i && (owner_o != LAST_IDX) |=> owner_o == $past(owner_o) + IDX_W'(1));
    p_owner_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i && (owner_o == LAST_IDX) |=> owner_o == '0);
    p_owner_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        owner_o <= LAST_IDX);
endmodule

// File: rtl/tsa_grant_dec.sv
module tsa_grant_dec #(
    parameter int N_REQ = 4,
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic [IDX_W-1:0] owner_i,
    input  logic             slot_end_i,
    output logic             owner_req_o,
    output logic [N_REQ-1:0] grant_o
);
    typedef struct packed {
        logic lost;
    } dec_t;

    dec_t st_d, st_q;

    always_comb begin
        owner_req_o = req_i[owner_i];
        st_d.lost   = slot_end_i ? 1'b0 : (st_q.lost || !owner_req_o);
    end

    generate
        for (genvar g = 0; g < N_REQ; g++) begin : g_gnt
            assign grant_o[g] = (owner_i == IDX_W'(g)) && req_i[g] && !st_q.lost;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_forfeit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lost |-> grant_o == '0);
    p_drop_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !owner_req_o && !slot_end_i |=> grant_o == '0);
    p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);
endmodule

// File: rtl/tslice_arbiter.sv
module tslice_arbiter #(
    parameter int N_REQ = tsa_pkg::TSA_DEF_REQ,
    parameter int LEN_W = tsa_pkg::TSA_DEF_LEN_W,
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic [LEN_W-1:0] slice_len_i,
    input  logic             skip_idle_i,
    output logic [N_REQ-1:0] grant_o,
    output logic [IDX_W-1:0] owner_o,
    output logic             boundary_o
);
    logic slot_end;
    logic owner_req;
    logic end_early;

    assign end_early = skip_idle_i && !owner_req;

    tsa_slot_timer #(.LEN_W(LEN_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_i      (slice_len_i),
        .end_early_i(end_early),
        .slot_end_o (slot_end)
    );

    tsa_rotor #(.N_REQ(N_REQ)) u_rotor (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (slot_end),
        .owner_o   (owner_o),
        .boundary_o(boundary_o)
    );

    tsa_grant_dec #(.N_REQ(N_REQ)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .owner_i    (owner_o),
        .slot_end_i (slot_end),
        .owner_req_o(owner_req),
        .grant_o    (grant_o)
    );

    p_skip_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        skip_idle_i && !req_i[owner_o] |=> boundary_o);
    p_strobe_marks_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_o |-> owner_o != $past(owner_o));
    p_no_change_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_o |-> $stable(owner_o));
endmodule

// File: tb/tb_tslice_arbiter.sv
`timescale 1ns/1ps
module tb_tslice_arbiter;
    localparam int N  = 4;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_i = '0;
    logic [LW-1:0] slice_len_i = LW'(1);
    logic          skip_idle_i = 1'b0;
    logic [N-1:0]  grant_o;
    logic [1:0]    owner_o;
    logic          boundary_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    tslice_arbiter #(.N_REQ(N), .LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .slice_len_i(slice_len_i),
        .skip_idle_i(skip_idle_i), .grant_o(grant_o), .owner_o(owner_o),
        .boundary_o(boundary_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic do_reset(input int len, input bit skip, input logic [N-1:0] rq);
        rst_n = 1'b0;
        slice_len_i = LW'(len);
        skip_idle_i = skip;
        req_i = rq;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset_state();
        do_reset(3, 0, 4'b0000);
        chk("R3 owner after reset", owner_o, 0);
        chk("R3 grant after reset", grant_o, 0);
        chk("R3 strobe after reset", boundary_o, 0);
    endtask

    task automatic t_fair_rotation();
        int L = 3;
        int K = 2;
        int cnt[N];
        for (int i = 0; i < N; i++) cnt[i] = 0;
        do_reset(L, 0, 4'b1111);
        for (int c = 0; c < N * L * K; c++) begin
            chk("R2 owner order", owner_o, (c / L) % N);
            chk("R4 strobe", boundary_o, ((c % L) == 0 && c != 0) ? 1 : 0);
            chk("R5 onehot grant", grant_o, 1 << ((c / L) % N));
            for (int i = 0; i < N; i++) if (grant_o[i]) cnt[i]++;
            step();
        end
        for (int i = 0; i < N; i++) chk("R1 grant total", cnt[i], K * L);
    endtask

    task automatic t_single_requester();
        int tot = 0;
        do_reset(2, 0, 4'b0100);
        for (int c = 0; c < N * 2 * 2; c++) begin
            chk("R5 only owner with req", grant_o, (((c / 2) % N) == 2) ? 4 : 0);
            if (grant_o[2]) tot++;
            step();
        end
        chk("R1 single requester total", tot, 4);
    endtask

    task automatic t_forfeit();
        do_reset(4, 0, 4'b1111);
        repeat (4) step();
        chk("R2 owner at slot1", owner_o, 1);
        chk("R5 grant slot1", grant_o, 2);
        req_i = 4'b1101; #1;
        chk("R5 grant drops with req", grant_o, 0);
        step();
        req_i = 4'b1111; #1;
        chk("R6 no regrant c5", grant_o, 0);
        step();
        chk("R6 no regrant c6", grant_o, 0);
        step();
        chk("R6 no regrant c7", grant_o, 0);
        step();
        chk("R6 next slot owner", owner_o, 2);
        chk("R6 next slot grant", grant_o, 4);
    endtask

    task automatic t_skip_idle();
        int exp_own[9] = '{0, 1, 2, 2, 2, 3, 0, 1, 2};
        do_reset(3, 1, 4'b0100);
        for (int c = 0; c < 9; c++) begin
            chk("R7 skip owner", owner_o, exp_own[c]);
            step();
        end
        do_reset(3, 0, 4'b0100);
        repeat (3) step();
        chk("R7 no skip keeps idle slot", owner_o, 1);
    endtask

    task automatic t_len_change();
        do_reset(2, 0, 4'b1111);
        slice_len_i = LW'(3);
        step();
        chk("R8 running slot keeps old len c1", owner_o, 0);
        step();
        chk("R8 new slot c2", owner_o, 1);
        step(); step();
        chk("R8 new len c4", owner_o, 1);
        step();
        chk("R8 new len ended c5", owner_o, 2);
    endtask

    task automatic t_zero_len();
        do_reset(0, 0, 4'b1111);
        for (int c = 0; c < 6; c++) begin
            chk("R9 zero len acts as one", owner_o, c % N);
            step();
        end
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_fair_rotation();
        t_single_requester();
        t_forfeit();
        t_skip_idle();
        t_len_change();
        t_zero_len();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule